// File: doc/BRIEF.md
# Rotating-Offset Burst Read Proxy

This block sits between a memory read path that returns fixed-width bursts and a compute kernel that consumes a different, runtime-chosen number of elements every cycle. A burst carries up to `LANES` elements plus a length. Its elements are spread over `LANES` parallel lane FIFOs. The first one goes into the FIFO under a rotating write offset, and the offset then moves past the elements just written. Because of this, the lane FIFOs together behave as one ordered element stream, whatever mix of burst lengths arrives.

On the read side, the kernel asks for a count of elements below `LANES`. When enough elements are buffered, the proxy pops them from the FIFOs, starting at a rotating read offset. It packs them, oldest first, into the low lanes of a fixed `LANES`-wide output word and fills the remaining lanes with zeros. While too few elements are buffered, the request is held off, and the kernel keeps its request strobe asserted until it is accepted.

Top module: `burst_read_proxy`

## Requirements
- R1: After reset the output valid is low, no element is buffered, a burst of any length is accepted, and a request is accepted only if its count is zero.
- R2: Element lane `i` (bits `i*DATA_W` upward) of an accepted burst, for `i` below `burst_len_i`, goes into lane FIFO `(w + i) mod LANES`, where `w` is the write offset. The write offset then advances by `burst_len_i mod LANES`, so the elements leave in arrival order across bursts of any length.
- R3: A request is accepted in a cycle where `req_i` and `req_ready_o` are both high. `req_ready_o` is high exactly when the number of buffered elements is at least `req_cnt_i`. `out_valid_o` is high in the cycle after an accepted request.
- R4: For an accepted request of count `m`, output lane `j` with `j < m` holds the `j`-th oldest buffered element, and those `m` elements are removed.
- R5: Output lanes with index `m` and above are zero in a valid output word.
- R6: An accepted request with count zero yields a valid all-zero word, removes nothing and leaves the read offset unchanged.
- R7: `burst_ready_o` is high exactly when every lane FIFO that the burst would write into has a free slot. Because the FIFOs stay balanced, this means a zero length, or buffered count plus `burst_len_i` no larger than `LANES*FIFO_DEPTH`. A refused burst leaves the stream unchanged.
- R8: In a cycle that follows no accepted request, `out_valid_o` is low and `out_data_o` is all zero.
- R9: A burst and a request accepted in the same cycle both take effect. The request is served from the elements buffered before that burst, and its readiness does not count them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_valid_i | input | 1 | Burst present |
| burst_len_i | input | $clog2(LANES+1) | Number of valid elements in the burst, lanes 0 upward |
| burst_data_i | input | LANES*DATA_W | Burst elements, lane `i` at bits `i*DATA_W` |
| burst_ready_o | output | 1 | Burst would be accepted |
| req_i | input | 1 | Request strobe, held until accepted |
| req_cnt_i | input | $clog2(LANES) | Number of elements requested, 0 to LANES-1 |
| req_ready_o | output | 1 | Enough elements buffered for the request |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | LANES*DATA_W | Packed, zero-padded output, lane `j` at bits `j*DATA_W` |

## Verification
Both ready outputs are combinational, so they are due in the same cycle as the inputs they depend on. The bench samples them one time unit after it drives new inputs, always before the next rising edge. The output word is registered once, so it is due in the cycle after the accepted request. The bench keeps the expected word from the previous cycle's decision and compares it at the following falling edge, before it drives new stimulus. A reference queue is advanced at each decision, with the pop taken before the push, so the timing of a same-cycle burst and request matches R9.

// File: rtl/brp_pkg.sv
package brp_pkg;
  typedef logic [7:0] idx_t;

  // (a + b) mod n, with a < n and b <= n
  function automatic idx_t mod_add(idx_t a, idx_t b, idx_t n);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[7:0];
  endfunction

  // (a - b) mod n, with a < n and b < n
  function automatic idx_t mod_sub(idx_t a, idx_t b, idx_t n);
    return mod_add(a, n - b, n);
  endfunction
endpackage

// File: rtl/brp_lane_fifo.sv
module brp_lane_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic [CW-1:0]     count_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr_q];
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;
endmodule

// File: rtl/brp_scatter.sv
module brp_scatter #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 2,
  parameter int LEN_W  = 3
) (
  input  logic                    valid_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]        wr_off_i,
  input  logic [LANES-1:0]        full_i,
  output logic                    ready_o,
  output logic [LANES-1:0]        push_o,
  output logic [LANES*DATA_W-1:0] push_data_o,
  output logic [PTR_W-1:0]        next_off_o
);
  import brp_pkg::*;

  logic [DATA_W-1:0] in_lane [LANES];
  logic [LANES-1:0]  target;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign in_lane[g] = data_i[g*DATA_W +: DATA_W];
  end

  for (genvar f = 0; f < LANES; f++) begin : g_fifo
    logic [PTR_W-1:0] rel;
    // burst element index that lands in FIFO f
    assign rel       = PTR_W'(mod_sub(idx_t'(f), idx_t'(wr_off_i), idx_t'(LANES)));
    assign target[f] = idx_t'(rel) < idx_t'(len_i);
    assign push_o[f] = valid_i && ready_o && target[f];
    assign push_data_o[f*DATA_W +: DATA_W] = in_lane[rel];
  end

  assign ready_o    = &(~target | ~full_i);
  assign next_off_o = PTR_W'(mod_add(idx_t'(wr_off_i), idx_t'(len_i), idx_t'(LANES)));
endmodule

// File: rtl/brp_gather.sv
module brp_gather #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 2,
  parameter int TOT_W  = 5
) (
  input  logic                    req_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [TOT_W-1:0]        total_i,
  input  logic [PTR_W-1:0]        rd_off_i,
  input  logic [LANES*DATA_W-1:0] head_i,
  output logic                    ready_o,
  output logic                    fire_o,
  output logic [LANES-1:0]        pop_o,
  output logic [LANES*DATA_W-1:0] lanes_o,
  output logic [PTR_W-1:0]        next_off_o
);
  import brp_pkg::*;

  logic [DATA_W-1:0] head_lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign head_lane[g] = head_i[g*DATA_W +: DATA_W];
  end

  assign ready_o = total_i >= TOT_W'(cnt_i);
  assign fire_o  = req_i && ready_o;

  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [PTR_W-1:0] src;
    assign src = PTR_W'(mod_add(idx_t'(rd_off_i), idx_t'(j), idx_t'(LANES)));
    assign lanes_o[j*DATA_W +: DATA_W] =
      (idx_t'(j) < idx_t'(cnt_i)) ? head_lane[src] : '0;
  end

  for (genvar f = 0; f < LANES; f++) begin : g_pop
    logic [PTR_W-1:0] rel;
    assign rel      = PTR_W'(mod_sub(idx_t'(f), idx_t'(rd_off_i), idx_t'(LANES)));
    assign pop_o[f] = fire_o && (idx_t'(rel) < idx_t'(cnt_i));
  end

  assign next_off_o = PTR_W'(mod_add(idx_t'(rd_off_i), idx_t'(cnt_i), idx_t'(LANES)));
endmodule

// File: rtl/burst_read_proxy.sv
module burst_read_proxy #(
  parameter int LANES      = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int PTR_W     = $clog2(LANES),
  localparam int LEN_W     = $clog2(LANES + 1),
  localparam int CNT_W     = $clog2(LANES),
  localparam int FCW       = $clog2(FIFO_DEPTH + 1),
  localparam int TOT_W     = $clog2(LANES * FIFO_DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    burst_valid_i,
  input  logic [LEN_W-1:0]        burst_len_i,
  input  logic [LANES*DATA_W-1:0] burst_data_i,
  output logic                    burst_ready_o,
  input  logic                    req_i,
  input  logic [CNT_W-1:0]        req_cnt_i,
  output logic                    req_ready_o,
  output logic                    out_valid_o,
  output logic [LANES*DATA_W-1:0] out_data_o
);
  logic [PTR_W-1:0]        wr_off_q, rd_off_q, wr_next, rd_next;
  logic [LANES-1:0]        push_w, pop_w, full_w;
  logic [LANES*DATA_W-1:0] push_data_w, head_w, lanes_w;
  logic [FCW-1:0]          fifo_cnt [LANES];
  logic [TOT_W-1:0]        total;
  logic                    burst_fire, req_fire;
  logic                    out_valid_q;
  logic [LANES*DATA_W-1:0] out_data_q;

  brp_scatter #(
    .LANES(LANES), .DATA_W(DATA_W), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_scatter (
    .valid_i     (burst_valid_i),
    .len_i       (burst_len_i),
    .data_i      (burst_data_i),
    .wr_off_i    (wr_off_q),
    .full_i      (full_w),
    .ready_o     (burst_ready_o),
    .push_o      (push_w),
    .push_data_o (push_data_w),
    .next_off_o  (wr_next)
  );

  for (genvar f = 0; f < LANES; f++) begin : g_lane
    brp_lane_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push_w[f]),
      .push_data_i (push_data_w[f*DATA_W +: DATA_W]),
      .pop_i       (pop_w[f]),
      .head_o      (head_w[f*DATA_W +: DATA_W]),
      .full_o      (full_w[f]),
      .count_o     (fifo_cnt[f])
    );
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total = total + TOT_W'(fifo_cnt[i]);
  end

  brp_gather #(
    .LANES(LANES), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .TOT_W(TOT_W)
  ) u_gather (
    .req_i      (req_i),
    .cnt_i      (req_cnt_i),
    .total_i    (total),
    .rd_off_i   (rd_off_q),
    .head_i     (head_w),
    .ready_o    (req_ready_o),
    .fire_o     (req_fire),
    .pop_o      (pop_w),
    .lanes_o    (lanes_w),
    .next_off_o (rd_next)
  );

  assign burst_fire = burst_valid_i && burst_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_off_q    <= '0;
      rd_off_q    <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (burst_fire) wr_off_q <= wr_next;
      if (req_fire)   rd_off_q <= rd_next;
      out_valid_q <= req_fire;
      out_data_q  <= req_fire ? lanes_w : '0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/burst_read_proxy_chk.sv
module burst_read_proxy_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic [CNT_W-1:0]        req_cnt_i,
  input logic                    req_ready_o,
  input logic                    out_valid_o,
  input logic [LANES*DATA_W-1:0] out_data_o,
  input logic [PTR_W-1:0]        rd_off_q,
  input logic [LANES-1:0]        push_w,
  input logic [LANES-1:0]        full_w
);
  logic [CNT_W-1:0] last_cnt;
  logic             pad_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  last_cnt <= '0;
    else if (req_i && req_ready_o) last_cnt <= req_cnt_i;
  end

  always_comb begin
    pad_ok = 1'b1;
    for (int j = 0; j < LANES; j++)
      if (j >= int'(last_cnt) && out_data_o[j*DATA_W +: DATA_W] != '0) pad_ok = 1'b0;
  end

  p_ack_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_ready_o) |=> out_valid_o);

  p_zero_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_cnt_i == '0) |-> req_ready_o);

  p_pad_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pad_ok);

  p_zero_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_ready_o && req_cnt_i == '0) |=> (out_data_o == '0 && $stable(rd_off_q)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_w & full_w) == '0);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && req_ready_o) |=> (!out_valid_o && out_data_o == '0));
endmodule

bind burst_read_proxy burst_read_proxy_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .req_cnt_i   (req_cnt_i),
  .req_ready_o (req_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .rd_off_q    (rd_off_q),
  .push_w      (push_w),
  .full_w      (full_w)
);

// File: tb/burst_read_proxy_bench.sv
module burst_read_proxy_bench;
  localparam int LANES  = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int CAP    = LANES * DEPTH;
  localparam int LEN_W  = $clog2(LANES + 1);
  localparam int CNT_W  = $clog2(LANES);
  localparam int W      = LANES * DATA_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             burst_valid_i = 1'b0;
  logic [LEN_W-1:0] burst_len_i = '0;
  logic [W-1:0]     burst_data_i = '0;
  logic             burst_ready_o;
  logic             req_i = 1'b0;
  logic [CNT_W-1:0] req_cnt_i = '0;
  logic             req_ready_o;
  logic             out_valid_o;
  logic [W-1:0]     out_data_o;

  always #5 clk_i = ~clk_i;

  burst_read_proxy #(.LANES(LANES), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) u_burst_read_proxy (
    .clk_i, .rst_ni, .burst_valid_i, .burst_len_i, .burst_data_i, .burst_ready_o,
    .req_i, .req_cnt_i, .req_ready_o, .out_valid_o, .out_data_o
  );

  int unsigned       n_cmp = 0, n_bad = 0;
  logic [DATA_W-1:0] q [$];
  logic              exp_valid = 1'b0;
  logic [W-1:0]      exp_data = '0;
  int                exp_cnt = 0;
  string             exp_tag = "R8";
  string             cur_tag = "R4";
  logic [DATA_W-1:0] seq = 16'h1000;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane_mask(int cnt);
    logic [W-1:0] m = '0;
    for (int j = 0; j < LANES; j++) if (j < cnt) m[j*DATA_W +: DATA_W] = '1;
    return m;
  endfunction

  function automatic logic [W-1:0] seq_burst(logic [DATA_W-1:0] base);
    logic [W-1:0] d = '0;
    for (int j = 0; j < LANES; j++) d[j*DATA_W +: DATA_W] = base + DATA_W'(j);
    return d;
  endfunction

  task automatic step(input logic bv, input int blen, input logic [W-1:0] bdata,
                      input logic rq, input int rcnt);
    logic exp_br, exp_rr, acc_b, acc_r;
    @(negedge clk_i);
    chk(exp_tag, "out_valid", W'(out_valid_o), W'(exp_valid));
    if (exp_valid) begin
      chk(exp_tag, "used lanes", out_data_o & lane_mask(exp_cnt), exp_data);
      chk("R5", "pad lanes", out_data_o & ~lane_mask(exp_cnt), '0);
    end else begin
      chk("R8", "idle data", out_data_o, '0);
    end
    burst_valid_i = bv;
    burst_len_i   = LEN_W'(blen);
    burst_data_i  = bdata;
    req_i         = rq;
    req_cnt_i     = CNT_W'(rcnt);
    #1;
    exp_br = (blen == 0) || (q.size() + blen <= CAP);
    exp_rr = q.size() >= rcnt;
    chk("R7", "burst_ready", W'(burst_ready_o), W'(exp_br));
    chk("R3", "req_ready", W'(req_ready_o), W'(exp_rr));
    acc_b = bv && exp_br;
    acc_r = rq && exp_rr;
    if (acc_r) begin
      exp_valid = 1'b1;
      exp_cnt   = rcnt;
      exp_data  = '0;
      for (int j = 0; j < rcnt; j++) exp_data[j*DATA_W +: DATA_W] = q.pop_front();
      exp_tag = (acc_b) ? "R9" : (rcnt == 0) ? "R6" : cur_tag;
    end else begin
      exp_valid = 1'b0;
      exp_cnt   = 0;
      exp_data  = '0;
      exp_tag   = "R8";
    end
    if (acc_b)
      for (int j = 0; j < blen; j++) q.push_back(bdata[j*DATA_W +: DATA_W]);
  endtask

  task automatic idle();
    step(1'b0, 0, '0, 1'b0, 0);
  endtask

  task automatic push_seq(input int blen);
    step(1'b1, blen, seq_burst(seq), 1'b0, 0);
    seq = seq + 16'h0010;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    @(negedge clk_i);
    burst_len_i = LEN_W'(LANES);
    req_cnt_i   = CNT_W'(1);
    #1;
    chk("R1", "out_valid after reset", W'(out_valid_o), '0);
    chk("R1", "burst_ready after reset", W'(burst_ready_o), W'(1));
    chk("R1", "req_ready cnt1 after reset", W'(req_ready_o), '0);
    req_cnt_i = '0;
    #1;
    chk("R1", "req_ready cnt0 after reset", W'(req_ready_o), W'(1));

    // R2: mixed burst lengths, then read back in order
    cur_tag = "R2";
    push_seq(3); push_seq(1); push_seq(4); push_seq(2); push_seq(0); push_seq(3);
    step(1'b0, 0, '0, 1'b1, 3);
    step(1'b0, 0, '0, 1'b1, 2);
    step(1'b0, 0, '0, 1'b1, 1);
    step(1'b0, 0, '0, 1'b1, 3);
    step(1'b0, 0, '0, 1'b1, 3);
    step(1'b0, 0, '0, 1'b1, 1);
    // R3: request held while too few elements
    step(1'b0, 0, '0, 1'b1, 3);
    step(1'b0, 0, '0, 1'b1, 3);

    // R7: fill to capacity, refused bursts must not enter the stream
    cur_tag = "R7";
    for (int i = 0; i < 5; i++) push_seq(4);
    push_seq(1);
    push_seq(0);
    // R6: zero-count requests with data buffered
    step(1'b0, 0, '0, 1'b1, 0);
    step(1'b0, 0, '0, 1'b1, 0);
    while (q.size() >= 3) step(1'b0, 0, '0, 1'b1, 3);
    while (q.size() > 0) step(1'b0, 0, '0, 1'b1, 1);
    step(1'b0, 0, '0, 1'b1, 0);

    // R9: concurrent burst and request
    cur_tag = "R9";
    push_seq(2);
    step(1'b1, 3, seq_burst(16'h7000), 1'b1, 2);
    step(1'b1, 4, seq_burst(16'h7100), 1'b1, 3);
    step(1'b0, 0, '0, 1'b1, 3);
    idle();

    // random mix
    cur_tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d;
      d = {$urandom(), $urandom()};
      step(($urandom() % 2) == 0, int'($urandom() % (LANES + 1)), d,
           ($urandom() % 5) < 3, int'($urandom() % LANES));
    end
    while (q.size() >= 3) step(1'b0, 0, '0, 1'b1, 3);
    while (q.size() > 0) step(1'b0, 0, '0, 1'b1, 1);
    idle();
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule